// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block divides a shared packet buffer into fixed-size pages, and it gives out packet numbers on request. A packet occupies one page, and its packet number is the index of that page, so the number also serves as the page address for the data path. A host issues three-bit commands with a packet-number argument. The commands allocate, release, queue for transmit, take from the receive queue, and clear state. After each allocate, the host reads a result register that holds a failure flag.

The receive side of the MAC asks for pages through its own request line. Each granted page goes straight onto a receive queue for the host to collect. Transmit and receive draw on the same pool of pages. A host-written reservation, given in memory units of a quarter page, caps how many pages receive traffic may hold at once. The free-memory and total-memory readouts use the same units. Their 8-bit fields read FFh when the true count is 256.

Top module: `pba_alloc`

## Requirements
- R1: After reset the block shows the following. free_units and mem_size read 8'hFF. res_failed is 1 and res_pkt is 0. busy is 0. Both queues are empty.
- R2: Opcode 0 (allocate) takes the lowest-numbered free page. It returns that page as res_pkt with res_failed 0, and free_units falls by 4.
- R3: Opcode 0 with no free page sets res_failed to 1. res_pkt keeps its previous value and free_units is unchanged.
- R4: A command accepted at one clock edge raises busy for exactly the next cycle. Its result appears when busy falls. A command presented while busy is high is ignored.
- R5: Opcode 4 frees the page named in cmd_arg. Freeing a page that is already free has no effect.
- R6: Opcode 1 frees every page and empties both queues.
- R7: An rx_req in a cycle with no command executing is answered next cycle with rx_ack. It succeeds only if a page is free and the pages held by receive number fewer than the total minus the reserved pages. On success the lowest free page is granted, reported in rx_pkt and pushed onto the receive queue. On failure rx_fail is 1 and nothing changes.
- R8: Reserved pages are resv_val divided by 4, rounded down. The exception is 8'hFF, which reserves all pages.
- R9: Opcode 2 pops the top of the receive queue without freeing it. Opcode 3 pops the top and frees that page, which no longer counts as held by receive. On an empty queue both have no effect.
- R10: Opcode 6 appends cmd_arg to the transmit queue, and tx_pop removes its oldest entry. Opcode 5 empties the transmit queue and frees no page.
- R11: free_units reads the free page count times 4, or 8'hFF when that product exceeds 255. Opcode 7 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_arg | input | 6 | Packet number argument |
| busy | output | 1 | Command executing |
| res_pkt | output | 6 | Last allocated packet number |
| res_failed | output | 1 | Last allocate failed |
| resv_we | input | 1 | Reservation write strobe |
| resv_wdata | input | 8 | Reservation value in units |
| resv_val | output | 8 | Current reservation |
| free_units | output | 8 | Free memory in units |
| mem_size | output | 8 | Total memory in units |
| rx_req | input | 1 | Receive page request |
| rx_ack | output | 1 | Receive request answered |
| rx_fail | output | 1 | Receive request refused |
| rx_pkt | output | 6 | Granted receive packet |
| rx_top | output | 6 | Head of receive queue |
| rx_empty | output | 1 | Receive queue empty |
| tx_pop | input | 1 | Remove transmit queue head |
| tx_top | output | 6 | Head of transmit queue |
| tx_empty | output | 1 | Transmit queue empty |

## Verification
Allocation is tested on a pool with holes punched by releases. This shows whether the lowest free page is chosen rather than the next in sequence. Allocation is also tested on an exhausted pool, which separates the failure path from normal allocation. The same receive request is made under reservations of F0h, F3h, FFh and zero. Together these show that the low bits are floored and that FFh is the full-reservation code. A command held through the busy cycle and the two receive-queue removal opcodes show whether a second command is accepted and whether a page is freed.

// File: rtl/pba_pkg.sv
// Shared opcode type for the paged buffer allocator.
package pba_pkg;
    typedef enum logic [2:0] {
        OP_ALLOC       = 3'd0,
        OP_RESET_ALL   = 3'd1,
        OP_RX_POP      = 3'd2,
        OP_RX_POP_FREE = 3'd3,
        OP_FREE_PKT    = 3'd4,
        OP_RESET_TX    = 3'd5,
        OP_TX_PUSH     = 3'd6,
        OP_NOP         = 3'd7
    } op_e;
endpackage

// File: rtl/pba_page_map.sv
// Free-page bitmap with a free counter and a lowest-free-page finder.
// Assumes at most one set and one clear request per cycle.
module pba_page_map #(
    parameter int NUM_PAGES = 64,
    localparam int PKT_W = $clog2(NUM_PAGES),
    localparam int CNT_W = $clog2(NUM_PAGES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_all,
    input  logic                 set_en,
    input  logic [PKT_W-1:0]     set_idx,
    input  logic                 clr_en,
    input  logic [PKT_W-1:0]     clr_idx,
    output logic [NUM_PAGES-1:0] used,
    output logic [CNT_W-1:0]     free_cnt,
    output logic                 any_free,
    output logic [PKT_W-1:0]     first_free
);
    logic do_set, do_clr;

    // Qualify requests against the current bitmap
    always_comb begin
        do_set = set_en && !used[set_idx];
        do_clr = clr_en && used[clr_idx];
    end

    // Bitmap and free counter update
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            used     <= '0;
            free_cnt <= CNT_W'(NUM_PAGES);
        end else begin
            if (do_set) used[set_idx] <= 1'b1;
            if (do_clr) used[clr_idx] <= 1'b0;
            free_cnt <= free_cnt - CNT_W'(do_set) + CNT_W'(do_clr);
        end
    end

    // Lowest-numbered free page
    always_comb begin
        first_free = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (!used[i]) first_free = PKT_W'(i);
        end
        any_free = (free_cnt != '0);
    end
endmodule

// File: rtl/pba_pkt_fifo.sv
// Show-ahead FIFO of packet numbers with a flush input.
// Push when full and pop when empty are dropped.
module pba_pkt_fifo #(
    parameter int W     = 6,
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]   mem [DEPTH];
    logic [PTR_W:0] wr_q, rd_q;
    logic           do_push, do_pop;

    // Status and head of queue
    always_comb begin
        empty   = (wr_q == rd_q);
        full    = (wr_q[PTR_W] != rd_q[PTR_W]) && (wr_q[PTR_W-1:0] == rd_q[PTR_W-1:0]);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rd_q[PTR_W-1:0]];
    end

    // Pointer update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q[PTR_W-1:0]] <= din;
    end
endmodule

// File: rtl/pba_alloc.sv
// Paged packet buffer allocator top. Decodes host commands (one-cycle
// busy window), serves receive page requests under a transmit
// reservation, and keeps receive and transmit queues of packet numbers.
// Assumes NUM_PAGES is a power of two; packet number equals page index.
module pba_alloc
    import pba_pkg::*;
#(
    parameter int NUM_PAGES  = 64,
    parameter int PAGE_UNITS = 4,
    localparam int PKT_W  = $clog2(NUM_PAGES),
    localparam int CNT_W  = $clog2(NUM_PAGES + 1),
    localparam int UNIT_W = 8,
    localparam int TOTAL_UNITS = NUM_PAGES * PAGE_UNITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [PKT_W-1:0]  cmd_arg,
    output logic              busy,
    output logic [PKT_W-1:0]  res_pkt,
    output logic              res_failed,
    input  logic              resv_we,
    input  logic [UNIT_W-1:0] resv_wdata,
    output logic [UNIT_W-1:0] resv_val,
    output logic [UNIT_W-1:0] free_units,
    output logic [UNIT_W-1:0] mem_size,
    input  logic              rx_req,
    output logic              rx_ack,
    output logic              rx_fail,
    output logic [PKT_W-1:0]  rx_pkt,
    output logic [PKT_W-1:0]  rx_top,
    output logic              rx_empty,
    input  logic              tx_pop,
    output logic [PKT_W-1:0]  tx_top,
    output logic              tx_empty
);
    localparam logic [UNIT_W-1:0] MEM_UNITS =
        (TOTAL_UNITS > 255) ? 8'hFF : UNIT_W'(TOTAL_UNITS);

    op_e                 op_q;
    logic [PKT_W-1:0]    arg_q;
    logic                pend_q;
    logic [NUM_PAGES-1:0] used, rx_own_q;
    logic [CNT_W-1:0]    free_cnt, rx_held_q, rx_limit;
    logic                any_free;
    logic [PKT_W-1:0]    first_free;
    logic                set_en, clr_en, clr_fire, reset_all, reset_tx;
    logic [PKT_W-1:0]    clr_idx;
    logic                rx_ok, rx_take, rx_pop_en, tx_push_en;
    logic                rx_full_unused, tx_full_unused;
    logic [15:0]         units_w, resv_pages;

    // Accept a command only when idle; busy covers the execute cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            op_q   <= OP_NOP;
            arg_q  <= '0;
        end else begin
            pend_q <= cmd_valid && !pend_q;
            if (cmd_valid && !pend_q) begin
                op_q  <= op_e'(cmd_op);
                arg_q <= cmd_arg;
            end
        end
    end

    assign busy = pend_q;

    // Reservation in pages and resulting receive limit
    always_comb begin
        if (resv_val == 8'hFF) resv_pages = 16'(NUM_PAGES);
        else                   resv_pages = 16'(resv_val) / 16'(PAGE_UNITS);
        if (resv_pages > 16'(NUM_PAGES)) resv_pages = 16'(NUM_PAGES);
        rx_limit = CNT_W'(16'(NUM_PAGES) - resv_pages);
        rx_ok    = any_free && (rx_held_q < rx_limit);
        rx_take  = rx_req && !pend_q && rx_ok;
    end

    // Command decode into page map and queue controls
    always_comb begin
        reset_all  = pend_q && (op_q == OP_RESET_ALL);
        reset_tx   = pend_q && (op_q == OP_RESET_TX);
        rx_pop_en  = pend_q && ((op_q == OP_RX_POP) || (op_q == OP_RX_POP_FREE));
        tx_push_en = pend_q && (op_q == OP_TX_PUSH);
        set_en     = (pend_q && (op_q == OP_ALLOC) && any_free) || rx_take;
        clr_en     = 1'b0;
        clr_idx    = arg_q;
        if (pend_q && (op_q == OP_FREE_PKT)) begin
            clr_en = 1'b1;
        end else if (pend_q && (op_q == OP_RX_POP_FREE) && !rx_empty) begin
            clr_en  = 1'b1;
            clr_idx = rx_top;
        end
        clr_fire = clr_en && used[clr_idx];
    end

    // Track which pages receive traffic holds
    always_ff @(posedge clk) begin
        if (!rst_n || reset_all) begin
            rx_own_q  <= '0;
            rx_held_q <= '0;
        end else begin
            if (rx_take) rx_own_q[first_free] <= 1'b1;
            if (clr_fire && rx_own_q[clr_idx]) rx_own_q[clr_idx] <= 1'b0;
            rx_held_q <= rx_held_q + CNT_W'(rx_take)
                         - CNT_W'(clr_fire && rx_own_q[clr_idx]);
        end
    end

    // Allocation result, receive answer and reservation registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_pkt    <= '0;
            res_failed <= 1'b1;
            rx_ack     <= 1'b0;
            rx_fail    <= 1'b0;
            rx_pkt     <= '0;
            resv_val   <= '0;
        end else begin
            if (pend_q && (op_q == OP_ALLOC)) begin
                res_failed <= !any_free;
                if (any_free) res_pkt <= first_free;
            end
            rx_ack  <= rx_req && !pend_q;
            rx_fail <= !rx_ok;
            if (rx_take) rx_pkt <= first_free;
            if (resv_we) resv_val <= resv_wdata;
        end
    end

    // Free memory readout in units
    always_comb begin
        units_w    = 16'(free_cnt) * 16'(PAGE_UNITS);
        free_units = (units_w > 16'd255) ? 8'hFF : units_w[7:0];
        mem_size   = MEM_UNITS;
    end

    pba_page_map #(.NUM_PAGES(NUM_PAGES)) u_map (
        .clk(clk), .rst_n(rst_n), .clear_all(reset_all),
        .set_en(set_en), .set_idx(first_free),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .used(used), .free_cnt(free_cnt),
        .any_free(any_free), .first_free(first_free)
    );

    pba_pkt_fifo #(.W(PKT_W), .DEPTH(NUM_PAGES)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(reset_all),
        .push(rx_take), .din(first_free), .pop(rx_pop_en),
        .dout(rx_top), .empty(rx_empty), .full(rx_full_unused)
    );

    pba_pkt_fifo #(.W(PKT_W), .DEPTH(NUM_PAGES)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(reset_all || reset_tx),
        .push(tx_push_en), .din(arg_q), .pop(tx_pop),
        .dout(tx_top), .empty(tx_empty), .full(tx_full_unused)
    );
endmodule

// Protocol checker for pba_alloc: busy window, result timing, and
// receive grant consistency seen at the ports.
module pba_alloc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       busy,
    input logic       res_failed,
    input logic       rx_ack,
    input logic       rx_fail,
    input logic       rx_empty,
    input logic [7:0] free_units
);
    a_r4_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    a_r4_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);
    a_r4_result_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable(res_failed));
    a_r7_grant_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && !rx_fail) |-> ($past(free_units) != 8'd0));
    a_r7_refusal_keeps_free: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && rx_fail) |-> $stable(free_units));
    a_r7_grant_queued: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && !rx_fail) |-> !rx_empty);
endmodule

bind pba_alloc pba_alloc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
    .res_failed(res_failed), .rx_ack(rx_ack), .rx_fail(rx_fail),
    .rx_empty(rx_empty), .free_units(free_units)
);

// File: tb/pba_alloc_tb.sv
module pba_alloc_tb;
    localparam int CLK_P = 10;
    localparam int NP = 64;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0; logic [2:0] cmd_op = 0; logic [5:0] cmd_arg = 0;
    logic busy, res_failed, rx_ack, rx_fail, rx_empty, tx_empty;
    logic [5:0] res_pkt, rx_pkt, rx_top, tx_top;
    logic resv_we = 0; logic [7:0] resv_wdata = 0;
    logic [7:0] resv_val, free_units, mem_size;
    logic rx_req = 0, tx_pop = 0;

    always #(CLK_P/2) clk = ~clk;

    pba_alloc u_dut (.*);

    int total = 0, fails = 0;
    bit done = 0;

    // reference model
    bit used_m [NP]; bit own_m [NP];
    int held_m = 0; int resv_m = 0;
    int rxq_m [$]; int txq_m [$];
    int res_pkt_m = 0; bit res_fail_m = 1;
    typedef struct { bit fail; int pkt; } exp_t;
    exp_t exp_res [$]; exp_t exp_rx [$];
    bit prev_busy = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int nfree();
        int n = 0;
        for (int i = 0; i < NP; i++) if (!used_m[i]) n++;
        return n;
    endfunction

    function automatic int lowest();
        for (int i = 0; i < NP; i++) if (!used_m[i]) return i;
        return -1;
    endfunction

    function automatic int units_m();
        return (nfree() * 4 > 255) ? 255 : nfree() * 4;
    endfunction

    function automatic void free_m(int p);
        if (used_m[p]) begin
            used_m[p] = 0;
            if (own_m[p]) begin own_m[p] = 0; held_m--; end
        end
    endfunction

    // scoreboard monitor: results pop when busy falls, rx answers on ack
    always @(negedge clk) begin
        if (rst_n && prev_busy && !busy) begin
            exp_t e;
            if (exp_res.size() == 0) chk("R4 unexpected result", 1, 0);
            else begin
                e = exp_res.pop_front();
                chk("R2/R3 res_failed", int'(res_failed), int'(e.fail));
                chk("R2/R3 res_pkt", int'(res_pkt), e.pkt);
            end
        end
        if (rst_n && rx_ack) begin
            exp_t e;
            if (exp_rx.size() == 0) chk("R7 unexpected ack", 1, 0);
            else begin
                e = exp_rx.pop_front();
                chk("R7 rx_fail", int'(rx_fail), int'(e.fail));
                if (!e.fail) chk("R7 rx_pkt", int'(rx_pkt), e.pkt);
            end
        end
        prev_busy = busy;
    end

    task automatic do_cmd(int op, int arg, int hold = 1);
        case (op)
            0: begin
                if (nfree() > 0) begin
                    res_pkt_m = lowest(); used_m[res_pkt_m] = 1; res_fail_m = 0;
                end else res_fail_m = 1;
            end
            1: begin
                for (int i = 0; i < NP; i++) begin used_m[i] = 0; own_m[i] = 0; end
                held_m = 0; rxq_m.delete(); txq_m.delete();
            end
            2: if (rxq_m.size() > 0) void'(rxq_m.pop_front());
            3: if (rxq_m.size() > 0) free_m(rxq_m.pop_front());
            4: free_m(arg);
            5: txq_m.delete();
            6: if (txq_m.size() < NP) txq_m.push_back(arg);
            default: ;
        endcase
        exp_res.push_back('{res_fail_m, res_pkt_m});
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_arg = 6'(arg);
        @(negedge clk);
        chk("R4 busy after accept", int'(busy), 1);
        if (hold == 0) cmd_valid = 0;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic do_rx();
        int lim, p;
        bit ok;
        lim = (resv_m == 255) ? 0 : NP - ((resv_m / 4 > NP) ? NP : resv_m / 4);
        ok = (nfree() > 0) && (held_m < lim);
        p = lowest();
        if (ok) begin used_m[p] = 1; own_m[p] = 1; held_m++; rxq_m.push_back(p); end
        exp_rx.push_back('{!ok, p});
        @(negedge clk); rx_req = 1;
        @(negedge clk); rx_req = 0;
        chk("R7 rx_ack seen", int'(rx_ack), 1);
    endtask

    task automatic set_resv(int v);
        resv_m = v;
        @(negedge clk); resv_we = 1; resv_wdata = 8'(v);
        @(negedge clk); resv_we = 0;
        chk("R8 resv_val", int'(resv_val), v);
    endtask

    task automatic do_txpop();
        if (txq_m.size() > 0) void'(txq_m.pop_front());
        @(negedge clk); tx_pop = 1;
        @(negedge clk); tx_pop = 0;
    endtask

    task automatic state(string tag);
        chk({tag, " free_units"}, int'(free_units), units_m());
        chk({tag, " rx_empty"}, int'(rx_empty), int'(rxq_m.size() == 0));
        if (rxq_m.size() > 0) chk({tag, " rx_top"}, int'(rx_top), rxq_m[0]);
        chk({tag, " tx_empty"}, int'(tx_empty), int'(txq_m.size() == 0));
        if (txq_m.size() > 0) chk({tag, " tx_top"}, int'(tx_top), txq_m[0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 free_units", int'(free_units), 255);
        chk("R1 mem_size", int'(mem_size), 255);
        chk("R1 res_failed", int'(res_failed), 1);
        chk("R1 res_pkt", int'(res_pkt), 0);
        chk("R1 busy", int'(busy), 0);
        state("R1");
        // R2 sequential allocation
        do_cmd(0, 0); do_cmd(0, 0); do_cmd(0, 0);
        state("R2");
        // R4 command held through busy is taken once
        do_cmd(0, 0, 1);
        do_cmd(0, 0);
        chk("R4 second alloc number", int'(res_pkt), 4);
        // R5 free a hole, lowest reused; freeing a free page does nothing
        do_cmd(4, 1); state("R5");
        do_cmd(0, 0); chk("R5 hole reused", int'(res_pkt), 1);
        do_cmd(4, 9); state("R5 free of free page");
        // R11 no-op opcode
        do_cmd(7, 3); state("R11 nop");
        // R10 transmit queue
        do_cmd(6, 0); do_cmd(6, 2); state("R10 push");
        do_txpop(); state("R10 pop");
        do_cmd(6, 4); do_cmd(5, 0); state("R10 reset tx frees nothing");
        // R7/R8 reservation of 60 pages leaves 4 for receive
        set_resv(8'hF0);
        for (int i = 0; i < 5; i++) do_rx();
        state("R7 limit");
        set_resv(8'hF3); do_rx(); state("R8 low bits floored");
        set_resv(8'hFF); do_cmd(2, 0); do_rx(); state("R8 full reserve");
        // R9 pop without free then pop with free
        set_resv(0);
        do_cmd(2, 0); state("R9 pop keeps page");
        do_cmd(3, 0); state("R9 pop frees page");
        do_rx(); state("R9 receive reuses freed page");
        // R6 full reset
        do_cmd(6, 3);
        do_cmd(1, 0); state("R6");
        // R3 exhaust pool
        for (int i = 0; i < NP; i++) do_cmd(0, 0);
        state("R3 full");
        do_cmd(0, 0); state("R3 failed alloc");
        do_rx(); state("R7 no free page");
        repeat (3) @(negedge clk);
        chk("R4 scoreboard drained", exp_res.size() + exp_rx.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule